// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block carries out one multi-register load or store between a 16-entry, 32-bit register file and a word-wide memory. A start pulse supplies a base address, a 16-bit selection mask and five control bits: pre/post stepping, walking direction, user-bank request, base writeback and load/store. The block visits each selected register in turn and moves one word per memory beat. It reads or writes the register file through a plain read port and a plain write port.

Each memory word goes through a byte-order stage that a big-endian input selects. Register 15 receives special handling. A loaded value has its two low bits cleared and is also sent out as a branch request. A stored value is biased upward by 12. When the operation finishes, the block pulses a done flag, and it can offer the final stepped address as a writeback value for the base register. A user-bank request is not supported: the block refuses it and reports an error.

Top module: `blk_xfer_seq`

## Requirements
- R1: A start pulse seen while idle makes `busy` high from the next cycle until the cycle where `done` pulses. At that point `busy` is low, and `done` stays high for exactly one cycle.
- R2: With `up_dir`=1 the selected registers are transferred in ascending index order. With `up_dir`=0 they are transferred in descending order. Only indices whose `reg_mask` bit is 1 are transferred, one beat each.
- R3: The address moves by 4 per transfer: upward when `up_dir`=1, downward when `up_dir`=0. With `pre_step`=1 the step is taken before each beat, so the first beat uses base±4. With `pre_step`=0 the step is taken after each beat, so the first beat uses base.
- R4: With `wb_en`=1, `wb_we` pulses together with `done`, and `wb_data` holds base ± 4×(number of transferred registers). With `wb_en`=0, `wb_we` stays low.
- R5: On a load (`is_load`=1), each beat writes the byte-order-adjusted memory word into the register file at the register being transferred. On a store, `mem_we` is 1 and the register contents go out on `mem_wdata`.
- R6: When register 15 is loaded, the value written has bits 1..0 forced to 0. In that same cycle `redir_valid` pulses and `redir_pc` carries the same value.
- R7: When register 15 is stored, the word sent to memory is the register contents plus 12, before any byte reordering.
- R8: With `big_endian`=0, memory byte 0 is bits 7..0 of the register value. With `big_endian`=1, memory byte 0 is bits 31..24. The same rule applies in both directions.
- R9: A start with `user_bank`=1 causes no memory beat and no register write. In the next cycle `unsup_err` and `done` pulse together and `busy` stays low.
- R10: A start with an all-zero mask causes no memory beat, and `done` pulses in the next cycle. If `wb_en`=1, `wb_we` pulses with `wb_data` equal to the unchanged base.
- R11: Once `mem_req` is high, it stays high with the same `mem_addr` and `mem_we` until a cycle where `mem_ack` is high. A beat completes in that cycle.
- R12: A start pulse while `busy` is high is ignored. The operation in progress finishes unchanged, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| base_addr | input | 32 | Starting address |
| reg_mask | input | 16 | Register selection, bit i selects register i |
| pre_step | input | 1 | 1: step before each beat, 0: step after |
| up_dir | input | 1 | 1: ascending walk and increasing address |
| user_bank | input | 1 | User-bank request (unsupported) |
| wb_en | input | 1 | Request base writeback |
| is_load | input | 1 | 1: memory to registers, 0: registers to memory |
| big_endian | input | 1 | Byte order select |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| unsup_err | output | 1 | One-cycle pulse on a refused user-bank request |
| wb_we | output | 1 | Base writeback strobe (with done) |
| wb_data | output | 32 | Base writeback value |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1: write beat, 0: read beat |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted / read data valid |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| redir_valid | output | 1 | Branch request pulse on a loaded register 15 |
| redir_pc | output | 32 | Branch target |

## Verification
The bench runs every combination of pre/post stepping, walking direction, writeback and load/store in both byte orders. Each combination is tried with three masks. The full mask shows both the ordering and the total step. A mask with only the two end registers set tells ascending from descending walks by their first address and also exercises register 15. A sparse middle mask shows that unselected registers are skipped and left untouched. Memory acceptance is stalled at pseudo-random points to check that requests are held. Separate runs cover an empty mask with and without writeback, a refused user-bank request, and a start issued while busy.

// File: rtl/bxs_pkg.sv
// Shared constants and types for the block register transfer sequencer.
// Assumes a 16-entry register file in which entry 15 is the program counter.
package bxs_pkg;
    localparam int NREG          = 16;
    localparam int RIDX_W        = $clog2(NREG);
    localparam int WORD_W        = 32;
    localparam int BYTE_STEP     = WORD_W / 8;
    localparam int PC_IDX        = NREG - 1;
    localparam int PC_STORE_BIAS = 12;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BEAT = 1'b1
    } bxs_state_e;
endpackage

// File: rtl/bxs_pick.sv
// Selects the next register to transfer from the pending mask.
// Ascending walk returns the lowest set bit; descending walk returns the highest.
// Assumes the caller ignores idx when any is low.
module bxs_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic          up,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Priority search in the requested direction
    always_comb begin
        idx = '0;
        if (up) begin
            for (int i = N - 1; i >= 0; i--)
                if (pend[i]) idx = IW'(i);
        end else begin
            for (int i = 0; i < N; i++)
                if (pend[i]) idx = IW'(i);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/bxs_step.sv
// Address generator: produces the address of the current beat and the running
// address after it. Pre-step uses the stepped value for the beat; post-step
// uses the unstepped one. Either way the running address moves by STEP.
module bxs_step #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] cur_addr,
    input  logic          up,
    input  logic          pre,
    output logic [AW-1:0] beat_addr,
    output logic [AW-1:0] next_addr
);
    // Step in the walking direction, then choose which address the beat uses
    always_comb begin
        next_addr = up ? cur_addr + AW'(STEP) : cur_addr - AW'(STEP);
        beat_addr = pre ? next_addr : cur_addr;
    end
endmodule

// File: rtl/bxs_swap.sv
// Optional byte reversal of a word. With en low the word passes through;
// with en high byte k moves to byte (NB-1-k). Assumes W is a multiple of 8.
module bxs_swap #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    logic [W-1:0] rev;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/blk_xfer_seq.sv
// Block register transfer sequencer. One start pulse runs a whole
// multi-register load or store, one memory beat per selected register.
// Assumes a combinational register-file read port, and that mem_rdata is valid
// in the cycle mem_ack is high. Control inputs are sampled only at start.
module blk_xfer_seq
    import bxs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [WORD_W-1:0]   base_addr,
    input  logic [NREG-1:0]     reg_mask,
    input  logic                pre_step,
    input  logic                up_dir,
    input  logic                user_bank,
    input  logic                wb_en,
    input  logic                is_load,
    input  logic                big_endian,
    output logic                busy,
    output logic                done,
    output logic                unsup_err,
    output logic                wb_we,
    output logic [WORD_W-1:0]   wb_data,
    output logic [RIDX_W-1:0]   rf_raddr,
    input  logic [WORD_W-1:0]   rf_rdata,
    output logic                rf_we,
    output logic [RIDX_W-1:0]   rf_waddr,
    output logic [WORD_W-1:0]   rf_wdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                redir_valid,
    output logic [WORD_W-1:0]   redir_pc
);
    bxs_state_e          state_q;
    logic [NREG-1:0]     pend_q;
    logic [WORD_W-1:0]   addr_q;
    logic                pre_q, up_q, wben_q, load_q, big_q;
    logic                done_q, err_q, wbwe_q;
    logic [WORD_W-1:0]   wbd_q;

    logic [RIDX_W-1:0]   cur_idx;
    logic                cur_any;
    logic                cur_is_pc;
    logic [WORD_W-1:0]   beat_addr, next_addr;
    logic [WORD_W-1:0]   st_val, st_word, ld_word, ld_val;
    logic [NREG-1:0]     pend_after;
    logic                in_beat, beat_fire;

    bxs_pick #(.N(NREG), .IW(RIDX_W)) u_pick (
        .pend (pend_q),
        .up   (up_q),
        .idx  (cur_idx),
        .any  (cur_any)
    );

    bxs_step #(.AW(WORD_W), .STEP(BYTE_STEP)) u_step (
        .cur_addr  (addr_q),
        .up        (up_q),
        .pre       (pre_q),
        .beat_addr (beat_addr),
        .next_addr (next_addr)
    );

    bxs_swap #(.W(WORD_W)) u_swap_st (
        .en   (big_q),
        .din  (st_val),
        .dout (st_word)
    );

    bxs_swap #(.W(WORD_W)) u_swap_ld (
        .en   (big_q),
        .din  (mem_rdata),
        .dout (ld_word)
    );

    // Beat-level datapath: store bias, load alignment, strobes
    always_comb begin
        in_beat    = (state_q == ST_BEAT) && cur_any;
        beat_fire  = in_beat && mem_ack;
        cur_is_pc  = (cur_idx == RIDX_W'(PC_IDX));
        st_val     = rf_rdata + (cur_is_pc ? WORD_W'(PC_STORE_BIAS) : '0);
        ld_val     = cur_is_pc ? {ld_word[WORD_W-1:2], 2'b00} : ld_word;
        pend_after = pend_q & ~(NREG'(1) << cur_idx);
    end

    // Sequencing state: accept start, walk the mask, finish with writeback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            pre_q   <= 1'b0;
            up_q    <= 1'b0;
            wben_q  <= 1'b0;
            load_q  <= 1'b0;
            big_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            wbwe_q  <= 1'b0;
            wbd_q   <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            wbwe_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (user_bank) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else if (reg_mask == '0) begin
                            done_q <= 1'b1;
                            wbwe_q <= wb_en;
                            wbd_q  <= base_addr;
                        end else begin
                            state_q <= ST_BEAT;
                            pend_q  <= reg_mask;
                            addr_q  <= base_addr;
                            pre_q   <= pre_step;
                            up_q    <= up_dir;
                            wben_q  <= wb_en;
                            load_q  <= is_load;
                            big_q   <= big_endian;
                        end
                    end
                end
                ST_BEAT: begin
                    if (beat_fire) begin
                        pend_q <= pend_after;
                        addr_q <= next_addr;
                        if (pend_after == '0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            wbwe_q  <= wben_q;
                            wbd_q   <= next_addr;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q == ST_BEAT);
    assign done        = done_q;
    assign unsup_err   = err_q;
    assign wb_we       = wbwe_q;
    assign wb_data     = wbd_q;
    assign rf_raddr    = cur_idx;
    assign rf_we       = beat_fire && load_q;
    assign rf_waddr    = cur_idx;
    assign rf_wdata    = ld_val;
    assign mem_req     = in_beat;
    assign mem_we      = in_beat && !load_q;
    assign mem_addr    = beat_addr;
    assign mem_wdata   = st_word;
    assign redir_valid = rf_we && cur_is_pc;
    assign redir_pc    = ld_val;

    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                                       // R1
    AST_BEAT_IS_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> pend_q[rf_waddr]);                                               // R2
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> done);                                                             // R4
    AST_REDIR_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> rf_we && rf_waddr == RIDX_W'(PC_IDX) && redir_pc == rf_wdata
                        && redir_pc[1:0] == 2'b00);                                  // R6
    AST_UNSUP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && user_bank |=> unsup_err && done && !busy && !mem_req);     // R9
    AST_EMPTY_MASK_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && !user_bank && reg_mask == '0
        |=> done && !busy && wb_data == $past(base_addr));                           // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));   // R11
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> !unsup_err);                                               // R12
endmodule

// File: tb/sim_blk_xfer_seq.sv
`timescale 1ns/1ps
module sim_blk_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, pre_step, up_dir, user_bank, wb_en, is_load, big_endian;
    logic [31:0] base_addr;
    logic [15:0] reg_mask;
    logic        busy, done, unsup_err, wb_we, rf_we, mem_req, mem_we, mem_ack, redir_valid;
    logic [31:0] wb_data, rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata, redir_pc;
    logic [3:0]  rf_raddr, rf_waddr;

    always #4 clk = ~clk;

    blk_xfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .reg_mask(reg_mask),
        .pre_step(pre_step), .up_dir(up_dir), .user_bank(user_bank), .wb_en(wb_en),
        .is_load(is_load), .big_endian(big_endian), .busy(busy), .done(done),
        .unsup_err(unsup_err), .wb_we(wb_we), .wb_data(wb_data), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .redir_valid(redir_valid), .redir_pc(redir_pc)
    );

    // Models, all written from one process
    logic [31:0] rf [16];
    logic [31:0] mem [64];
    logic [31:0] log_a [32];
    logic        log_we [32];
    int          nbeat, nredir, nerr, hold_bad;
    logic [31:0] redir_val, hold_a;
    logic        hold_pend, init_req;
    logic [15:0] seed;
    logic [7:0]  lfsr;

    function automatic logic [31:0] rf_init(input int i, input logic [15:0] s);
        return {s[7:0], 4'(i), 4'hA, 8'(i * 37), 8'h3D ^ s[15:8]};
    endfunction
    function automatic logic [31:0] mem_init(input int j, input logic [15:0] s);
        return {8'(j * 13) + s[7:0], 8'hE1 ^ 8'(j), s[10:3], 8'(j) | 8'h03};
    endfunction
    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = mem[mem_addr[7:2]];
    assign mem_ack   = mem_req && (lfsr[0] || lfsr[2]);

    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < 16; i++) rf[i] <= rf_init(i, seed);
            for (int j = 0; j < 64; j++) mem[j] <= mem_init(j, seed);
            nbeat <= 0; nredir <= 0; nerr <= 0; hold_bad <= 0; hold_pend <= 1'b0;
        end else begin
            if (mem_req && mem_ack) begin
                if (nbeat < 32) begin
                    log_a[nbeat]  <= mem_addr;
                    log_we[nbeat] <= mem_we;
                end
                nbeat <= nbeat + 1;
                if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            end
            if (rf_we) rf[rf_waddr] <= rf_wdata;
            if (redir_valid) begin
                nredir    <= nredir + 1;
                redir_val <= redir_pc;
            end
            if (unsup_err) nerr <= nerr + 1;
            if (hold_pend && !(mem_req && mem_addr == hold_a)) hold_bad <= hold_bad + 1;
            hold_pend <= mem_req && !mem_ack;
            hold_a    <= mem_addr;
        end
    end

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // One complete operation with expected values computed arithmetically
    task automatic run_op(input bit p, input bit u, input bit s, input bit w, input bit l,
                          input bit big, input logic [15:0] mask, input logic [15:0] sd,
                          input bit intrude);
        logic [31:0] e_rf [16];
        logic [31:0] e_mem [64];
        logic [31:0] e_a [32];
        logic [31:0] a, st, v, e_pc;
        int          cnt, n, bad_i;
        bit          pc_ld, ok;
        logic        c_wbwe, c_err;
        logic [31:0] c_wbd;

        seed = sd;
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;

        for (int i = 0; i < 16; i++) e_rf[i] = rf_init(i, sd);
        for (int j = 0; j < 64; j++) e_mem[j] = mem_init(j, sd);
        a = 32'h80; cnt = 0; pc_ld = 0; e_pc = '0;
        if (!s) begin
            for (int k = 0; k < 16; k++) begin
                int r;
                r = u ? k : 15 - k;
                if (mask[r]) begin
                    st = u ? a + 32'd4 : a - 32'd4;
                    e_a[cnt] = p ? st : a;
                    if (l) begin
                        v = e_mem[e_a[cnt][7:2]];
                        if (big) v = bswap(v);
                        if (r == 15) begin v[1:0] = 2'b00; pc_ld = 1; e_pc = v; end
                        e_rf[r] = v;
                    end else begin
                        v = e_rf[r] + ((r == 15) ? 32'd12 : 32'd0);
                        e_mem[e_a[cnt][7:2]] = big ? bswap(v) : v;
                    end
                    a = st; cnt++;
                end
            end
        end

        base_addr = 32'h80; reg_mask = mask; pre_step = p; up_dir = u; user_bank = s;
        wb_en = w; is_load = l; big_endian = big; start = 1'b1;
        @(negedge clk); start = 1'b0; user_bank = 1'b0;
        if (s || mask == 16'h0)
            chk(!busy && done, "R1 no-beat op finishes at once", {busy, done}, 32'h1);
        else
            chk(busy && !done, "R1 busy after start", {busy, done}, 32'h2);
        if (intrude) begin
            reg_mask = 16'h0; user_bank = 1'b1; start = 1'b1;
            @(negedge clk); start = 1'b0; user_bank = 1'b0;
        end
        n = 0;
        while (!done && n < 400) begin @(negedge clk); n++; end
        chk(done, "R1 done reached", 32'(done), 32'h1);
        c_wbwe = wb_we; c_wbd = wb_data; c_err = unsup_err;

        if (s) begin
            chk(c_err && nbeat == 0, "R9 refused with error", {c_err, 8'(nbeat)}, 32'h100);
        end else begin
            chk(!c_err && nbeat == cnt, "R2 beat count", 32'(nbeat), 32'(cnt));
            ok = 1; bad_i = 0;
            for (int k = 0; k < cnt && k < 32; k++)
                if (ok && (log_a[k] != e_a[k] || log_we[k] != !l)) begin ok = 0; bad_i = k; end
            chk(ok, "R2 R3 beat address order", log_a[bad_i], e_a[bad_i]);
            chk(c_wbwe == w && (!w || c_wbd == a), "R4 R10 writeback",
                c_wbwe ? c_wbd : 32'hDEAD, w ? a : 32'hDEAD);
        end
        ok = 1; bad_i = 0;
        for (int i = 0; i < 16; i++) if (ok && rf[i] !== e_rf[i]) begin ok = 0; bad_i = i; end
        chk(ok, "R5 R6 R8 R12 register file", rf[bad_i], e_rf[bad_i]);
        ok = 1; bad_i = 0;
        for (int j = 0; j < 64; j++) if (ok && mem[j] !== e_mem[j]) begin ok = 0; bad_i = j; end
        chk(ok, "R5 R7 R8 R9 memory", mem[bad_i], e_mem[bad_i]);
        if (pc_ld) chk(nredir == 1 && redir_val == e_pc, "R6 redirect", redir_val, e_pc);
        else       chk(nredir == 0, "R6 no redirect", 32'(nredir), 32'h0);
        chk(hold_bad == 0, "R11 request held until ack", 32'(hold_bad), 32'h0);
        if (intrude) chk(nerr == 0, "R12 start while busy ignored", 32'(nerr), 32'h0);
        @(negedge clk);
        chk(!done && !busy, "R1 done is one cycle", {busy, done}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
        summary();
        $finish;
    end

    initial begin
        logic [15:0] masks [3];
        masks[0] = 16'hFFFF; masks[1] = 16'h8001; masks[2] = 16'h0530;
        lfsr = 8'h5A; init_req = 1'b0; seed = '0; rst_n = 1'b0; start = 1'b0;
        base_addr = '0; reg_mask = '0; pre_step = 0; up_dir = 0; user_bank = 0;
        wb_en = 0; is_load = 0; big_endian = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && !unsup_err && !wb_we && !rf_we,
            "R1 reset state", {busy, done, mem_req, unsup_err, wb_we, rf_we}, 32'h0);
        rst_n = 1'b1;
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 16; c++)
                for (int m = 0; m < 3; m++)
                    run_op(c[3], c[2], 1'b0, c[1], c[0], b[0], masks[m],
                           16'(c * 97 + m * 11 + b * 5000), 1'b0);
        run_op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0101, 1'b0); // R10 with wb
        run_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0202, 1'b0); // R10 no wb
        run_op(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0303, 1'b0); // R9
        run_op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h00F0, 16'h0404, 1'b0); // R9 store
        run_op(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'h0505, 1'b1); // R12
        run_op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0606, 1'b1); // R12
        summary();
        $finish;
    end
endmodule